// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block decides where each memory access in the upper-memory area of a 1 MB (20-bit) address space is served. The area from C0000h to FFFFFh is split into eight 16 KB segments (C0000h to DFFFFh) and two 64 KB segments (E0000h and F0000h). Each segment has a 2-bit attribute field. The field routes reads and writes independently, either to internal DRAM or to the external bus. Every address below C0000h is always served by DRAM.

The fields come from three control bytes that software programs elsewhere. This block only reads them. It also does two other things. It reports a shadow-BIOS flag taken from the F0000h segment field. It raises a one-cycle flush request whenever any attribute field changes value, so that cached translations of the old mapping can be discarded. The routing outputs are combinational from the address and the control bytes. The flush request comes from a register.

Top module: `shadow_route_top`

## Requirements
- R1: An access with an address below C0000h is routed to DRAM for both read and write, whatever the control bytes hold.
- R2: For addresses C0000h to CFFFFh, the field is taken from control byte `ctl_c`. The 16 KB segment selected by address bits 15:14 (values 0 to 3) uses bits [2k+1:2k] of the byte, with k equal to the value of those address bits.
- R3: For addresses D0000h to DFFFFh, the field is taken from control byte `ctl_d`. The bit layout by address bits 15:14 is the same as in R2.
- R4: The 64 KB segment at E0000h uses bits 7:6 of `ctl_ef`. The 64 KB segment at F0000h uses bits 5:4 of `ctl_ef`.
- R5: Field bit 1 set routes reads to DRAM; clear routes them to the bus. Field bit 0 set routes writes to DRAM; clear routes them to the bus. This gives four encodings:
  - 0: reads and writes both go to the bus.
  - 1: reads go to the bus, writes go to DRAM.
  - 2: reads go to DRAM, writes go to the bus.
  - 3: reads and writes both go to DRAM.
- R6: For a requested direction, exactly one of its DRAM or bus outputs is high. For a direction that is not requested, both of its outputs are low.
- R7: `shadow_bios` equals bit 5 of `ctl_ef`. A read in F0000h to FFFFFh while the flag is high goes to DRAM.
- R8: When any attribute field changes, `flush_pulse` is high during the clock cycle after the clock edge that first samples the new value. If the fields then stay steady, the pulse lasts exactly one cycle.
- R9: Bits 3:0 of `ctl_ef` have no effect. Changing them raises no flush and changes no routing.
- R10: The field values present at the first clock edge after reset release do not raise a flush, and `flush_pulse` is low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_c | input | 8 | Attribute fields for the four 16 KB segments C0000h–CFFFFh |
| ctl_d | input | 8 | Attribute fields for the four 16 KB segments D0000h–DFFFFh |
| ctl_ef | input | 8 | Bits 7:6 E0000h segment, bits 5:4 F0000h segment, bits 3:0 unused |
| acc_addr | input | 20 | Access address |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| rd_to_dram | output | 1 | Read served by internal DRAM |
| rd_to_bus | output | 1 | Read served by the external bus |
| wr_to_dram | output | 1 | Write served by internal DRAM |
| wr_to_bus | output | 1 | Write served by the external bus |
| shadow_bios | output | 1 | BIOS segment reads are shadowed |
| flush_pulse | output | 1 | One-cycle request to flush cached mappings |

## Verification
The four routing outputs and `shadow_bios` are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples them a few nanoseconds later, before the next rising edge. `flush_pulse` is registered. It is due at the falling edge that follows the first rising edge to see a changed field, and it must be low again one falling edge later. The bench samples at exactly those two points. For the reset case, the bench checks three falling edges after reset release.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

    localparam int ADDR_W      = 20;
    localparam int CTL_W       = 8;
    localparam int FIELD_W     = 2;
    localparam int FIELDS_PER  = CTL_W / FIELD_W;
    localparam int SEG_SEL_W   = 4;
    localparam int SEG_COUNT   = 1 << SEG_SEL_W;
    localparam int SEG_LSB     = 14;
    localparam int TRACK_W     = 2 * CTL_W + 2 * FIELD_W;

    typedef enum logic [1:0] {
        ATTR_BUS_BOTH  = 2'd0,
        ATTR_WR_DRAM   = 2'd1,
        ATTR_RD_DRAM   = 2'd2,
        ATTR_DRAM_BOTH = 2'd3
    } seg_attr_e;

    typedef struct packed {
        logic [TRACK_W-1:0] prev;
        logic               primed;
        logic               flush;
    } tracker_state_t;

endpackage

// File: rtl/seg_field_sel.sv
module seg_field_sel
    import shadow_route_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTL_W-1:0]  ctl_c,
    input  logic [CTL_W-1:0]  ctl_d,
    input  logic [CTL_W-1:0]  ctl_ef,
    output logic              in_upper,
    output seg_attr_e         attr
);
    localparam int HALF = SEG_COUNT / 2;
    localparam int QTR  = SEG_COUNT / 4;

    logic [FIELD_W-1:0]   field_tab [SEG_COUNT];
    logic [SEG_SEL_W-1:0] seg_idx;

    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
        if (i < FIELDS_PER) begin : g_c
            assign field_tab[i] = ctl_c[i*FIELD_W +: FIELD_W];
        end else if (i < HALF) begin : g_d
            assign field_tab[i] = ctl_d[(i-FIELDS_PER)*FIELD_W +: FIELD_W];
        end else if (i < HALF + QTR) begin : g_e
            assign field_tab[i] = ctl_ef[CTL_W-1 -: FIELD_W];
        end else begin : g_f
            assign field_tab[i] = ctl_ef[CTL_W-1-FIELD_W -: FIELD_W];
        end
    end

    always_comb begin
        in_upper = &addr[ADDR_W-1 -: 2];
        seg_idx  = addr[SEG_LSB +: SEG_SEL_W];
        attr     = seg_attr_e'(field_tab[seg_idx]);
    end
endmodule

// File: rtl/access_router.sv
module access_router
    import shadow_route_pkg::*;
(
    input  logic      in_upper,
    input  seg_attr_e attr,
    input  logic      rd,
    input  logic      wr,
    output logic      rd_dram,
    output logic      rd_bus,
    output logic      wr_dram,
    output logic      wr_bus
);
    logic rd_int;
    logic wr_int;

    always_comb begin
        rd_int  = !in_upper || (attr == ATTR_RD_DRAM) || (attr == ATTR_DRAM_BOTH);
        wr_int  = !in_upper || (attr == ATTR_WR_DRAM) || (attr == ATTR_DRAM_BOTH);
        rd_dram = rd && rd_int;
        rd_bus  = rd && !rd_int;
        wr_dram = wr && wr_int;
        wr_bus  = wr && !wr_int;
    end
endmodule

// File: rtl/flush_tracker.sv
module flush_tracker
    import shadow_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TRACK_W-1:0] fields,
    output logic               flush
);
    tracker_state_t st_d;
    tracker_state_t st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = fields;
        st_d.primed = 1'b1;
        st_d.flush  = st_q.primed && (fields != st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush = st_q.flush;
endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
    import shadow_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctl_c,
    input  logic [CTL_W-1:0]  ctl_d,
    input  logic [CTL_W-1:0]  ctl_ef,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic              rd_to_dram,
    output logic              rd_to_bus,
    output logic              wr_to_dram,
    output logic              wr_to_bus,
    output logic              shadow_bios,
    output logic              flush_pulse
);
    logic      in_upper;
    seg_attr_e attr;

    seg_field_sel u_sel (
        .addr     (acc_addr),
        .ctl_c    (ctl_c),
        .ctl_d    (ctl_d),
        .ctl_ef   (ctl_ef),
        .in_upper (in_upper),
        .attr     (attr)
    );

    access_router u_route (
        .in_upper (in_upper),
        .attr     (attr),
        .rd       (acc_rd),
        .wr       (acc_wr),
        .rd_dram  (rd_to_dram),
        .rd_bus   (rd_to_bus),
        .wr_dram  (wr_to_dram),
        .wr_bus   (wr_to_bus)
    );

    flush_tracker u_flush (
        .clk    (clk),
        .rst_n  (rst_n),
        .fields ({ctl_c, ctl_d, ctl_ef[CTL_W-1 -: 2*FIELD_W]}),
        .flush  (flush_pulse)
    );

    assign shadow_bios = ctl_ef[CTL_W-1-FIELD_W];
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk
    import shadow_route_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTL_W-1:0]  ctl_c,
    input logic [CTL_W-1:0]  ctl_d,
    input logic [CTL_W-1:0]  ctl_ef,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              rd_to_dram,
    input logic              rd_to_bus,
    input logic              wr_to_dram,
    input logic              wr_to_bus,
    input logic              shadow_bios,
    input logic              flush_pulse
);
    logic [TRACK_W-1:0] seen;
    logic [1:0]         age_q;

    assign seen = {ctl_c, ctl_d, ctl_ef[CTL_W-1 -: 2*FIELD_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    always_comb begin
        if (rst_n) begin
            assert_low_dram_R1: assert (!(acc_addr < 20'hC0000) ||
                ((rd_to_dram == acc_rd) && (wr_to_dram == acc_wr)));
            assert_one_hot_R6: assert ($onehot0({rd_to_dram, rd_to_bus}) &&
                $onehot0({wr_to_dram, wr_to_bus}) &&
                ((rd_to_dram || rd_to_bus) == acc_rd) &&
                ((wr_to_dram || wr_to_bus) == acc_wr));
            assert_bios_read_R7: assert (!(acc_rd && shadow_bios &&
                (acc_addr >= 20'hF0000)) || rd_to_dram);
        end
    end

    assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && flush_pulse) |-> ($past(seen) != $past(seen, 2)));

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(seen) == $past(seen, 2)) |-> !flush_pulse);

    assert_no_early_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd2) |-> !flush_pulse);
endmodule

bind shadow_route_top shadow_route_chk u_chk (.*);

// File: tb/shadow_route_top_tb.sv
module shadow_route_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctl_c = 8'h00;
    logic [7:0]  ctl_d = 8'h00;
    logic [7:0]  ctl_ef = 8'h00;
    logic [19:0] acc_addr = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic        rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus;
    logic        shadow_bios, flush_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shadow_route_top u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_c(ctl_c), .ctl_d(ctl_d), .ctl_ef(ctl_ef),
        .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .rd_to_dram(rd_to_dram), .rd_to_bus(rd_to_bus),
        .wr_to_dram(wr_to_dram), .wr_to_bus(wr_to_bus),
        .shadow_bios(shadow_bios), .flush_pulse(flush_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Four routing outputs packed as {rd_dram, rd_bus, wr_dram, wr_bus}
    function automatic logic [3:0] route_exp(input logic [1:0] f, input logic rd, input logic wr);
        return {rd && f[1], rd && !f[1], wr && f[0], wr && !f[0]};
    endfunction

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: nonzero fields across reset, no flush
        ctl_c = 8'h5A; ctl_d = 8'hC3; ctl_ef = 8'hF0;
        repeat (3) @(negedge clk);
        check("R10 flush in reset", {7'd0, flush_pulse}, 8'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #2;
            check("R10 flush after release", {7'd0, flush_pulse}, 8'h0);
        end

        // R1: low memory always DRAM, for both extremes of control bytes
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 12; a++) begin
                @(negedge clk);
                ctl_c = p ? 8'h00 : 8'hFF; ctl_d = ctl_c; ctl_ef = ctl_c;
                acc_addr = 20'(a * 20'h10000) + 20'h0ABC;
                acc_rd = 1'b1; acc_wr = 1'b1;
                #2;
                check("R1 low memory", {4'd0, rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus}, 8'h0A);
            end
        end

        // R2 R3 R4 R5 R6: sweep every segment, every encoding, every direction
        for (int seg = 0; seg < 16; seg++) begin
            for (int enc = 0; enc < 4; enc++) begin
                for (int dir = 0; dir < 4; dir++) begin
                    logic [1:0] other;
                    logic [7:0] fill;
                    logic [3:0] ex;
                    @(negedge clk);
                    other = ~2'(enc);
                    fill = {4{other}};
                    ctl_c = fill; ctl_d = fill; ctl_ef = {fill[7:4], 4'(seg + enc)};
                    if (seg < 4) ctl_c[seg*2 +: 2] = 2'(enc);
                    else if (seg < 8) ctl_d[(seg-4)*2 +: 2] = 2'(enc);
                    else if (seg < 12) ctl_ef[7:6] = 2'(enc);
                    else ctl_ef[5:4] = 2'(enc);
                    acc_addr = 20'hC0000 + 20'(seg * 20'h4000) + 20'h1357;
                    acc_rd = dir[0]; acc_wr = dir[1];
                    #2;
                    ex = route_exp(2'(enc), dir[0], dir[1]);
                    if (seg < 4)
                        check("R2 R5 R6 C-range route", {4'd0, rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus}, {4'd0, ex});
                    else if (seg < 8)
                        check("R3 R5 R6 D-range route", {4'd0, rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus}, {4'd0, ex});
                    else
                        check("R4 R5 R6 E/F-range route", {4'd0, rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus}, {4'd0, ex});
                end
            end
        end

        // R7: shadow flag tracks bit 5 and BIOS read goes to DRAM
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            ctl_ef = {2'b00, 2'(v), 4'b1010};
            acc_addr = 20'hFFFF0; acc_rd = 1'b1; acc_wr = 1'b0;
            #2;
            check("R7 shadow flag", {7'd0, shadow_bios}, {7'd0, v[1]});
            check("R7 bios read", {7'd0, rd_to_dram}, {7'd0, v[1]});
        end

        // settle fields
        @(negedge clk);
        ctl_c = 8'h00; ctl_d = 8'h00; ctl_ef = 8'h00;
        acc_rd = 1'b0; acc_wr = 1'b0;
        repeat (3) @(negedge clk);
        #2 check("R8 quiet before change", {7'd0, flush_pulse}, 8'h0);

        // R8: one change per field byte, pulse one cycle later, then low
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (k == 0) ctl_c = 8'h40;
            else if (k == 1) ctl_d = 8'h02;
            else ctl_ef = 8'h80;
            #2 check("R8 no pulse same cycle", {7'd0, flush_pulse}, 8'h0);
            @(negedge clk); #2;
            check("R8 pulse due", {7'd0, flush_pulse}, 8'h1);
            @(negedge clk); #2;
            check("R8 pulse ends", {7'd0, flush_pulse}, 8'h0);
        end

        // R9: unused bits change, no flush and routing unchanged
        @(negedge clk);
        acc_addr = 20'hE8000; acc_rd = 1'b1; acc_wr = 1'b1;
        #2;
        check("R9 route before", {4'd0, rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus}, 8'h09);
        @(negedge clk);
        ctl_ef = 8'h8F;
        #2;
        check("R9 route after", {4'd0, rd_to_dram, rd_to_bus, wr_to_dram, wr_to_bus}, 8'h09);
        @(negedge clk); #2;
        check("R9 no flush", {7'd0, flush_pulse}, 8'h0);
        @(negedge clk); #2;
        check("R9 still no flush", {7'd0, flush_pulse}, 8'h0);

        finish_run();
    end
endmodule